// File: doc/BRIEF.md
# Coprocessor Data Transfer Sequencer

This block is the coprocessor side of a load or store coprocessor instruction on a shared processor data bus. While idle it copies every word on the bus during an instruction fetch, so it always holds the most recently fetched instruction. When the processor issues that instruction, the block decodes it. If the instruction does not belong to this coprocessor, the block reports itself absent for one cycle. Otherwise it signals busy for a fixed number of cycles. It then moves one word per clock between the bus and its own small register file, and it ends the burst by raising absent and busy together.

The coprocessor sets the transfer length, not the processor. The processor keeps advancing the address one word per cycle until it sees both handshake lines high. Direction comes from a load/store bit. On a load the block writes bus words into consecutive registers. On a store it presents register contents and enables its output driver only while the external bus enable allows it.

The state machine has four states. ST_IDLE snoops fetches. ST_REJECT pulses absent. ST_WAIT holds busy. ST_XFER moves words. The transitions are:
- idle→reject on an issue that does not match.
- idle→wait on an issue that matches.
- wait→wait while the busy counter is above zero.
- wait→xfer when it reaches zero.
- xfer→xfer while words remain.
- xfer→idle on the last word.
- reject→idle unconditionally.

Top module: `cpx_xfer_seq`

## Requirements
- R1: After reset, absent, busy and bus output enable are low, the state is idle, and every register-file entry reads zero.
- R2: In idle, a high fetch indicator captures `bus_in` as the instruction copy at the clock edge. Fetch cycles during wait or transfer leave the copy unchanged, so a later issue with no new fetch repeats the earlier instruction.
- R3: An instruction is for this block when bits [27:25] equal 3'b110 and bits [11:8] equal the parameter CP_ID. An issue of any other instruction gives exactly one cycle with absent high and busy low, no bus drive, and then a return to idle.
- R4: An issue that matches gives exactly BUSY_CYC cycles (default 2) with busy high and absent low, starting in the cycle after the issue.
- R5: The transfer moves bits [3:0] + 1 words, one per clock, in consecutive cycles, right after the busy cycles.
- R6: Absent and busy are both high only in the final word cycle of a transfer. In the next cycle the block is idle with both low.
- R7: Bit 20 high selects a load. Word k of the burst is written from `bus_in` into register (base + k) mod NREGS, where base is bits [15:12].
- R8: Bit 20 low selects a store. During word k, `bus_out` carries register (base + k) mod NREGS, and `bus_oe` equals `bus_en_i`. Outside store word cycles `bus_oe` is low.
- R9: A reset asserted during a burst drops `bus_oe`, busy and absent at once, without waiting for a clock edge.
- R10: A count field of 15 moves 16 words, the maximum, and register indices wrap from NREGS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 1 | High while the bus carries an instruction fetch |
| issue_i | input | 1 | One-cycle strobe: the processor executes the held instruction |
| bus_en_i | input | 1 | External permission to drive the data bus |
| bus_in | input | 32 | Data bus as seen by the block |
| bus_out | output | 32 | Data presented for stores |
| bus_oe | output | 1 | Output enable for `bus_out` |
| absent_o | output | 1 | Absent handshake |
| busy_o | output | 1 | Busy handshake |

## Verification
The bench builds the block with its defaults: CP_ID = 5, BUSY_CYC = 2, NREGS = 16 and a 32-bit bus. With these values the largest count of 16 words spans the whole register file, so a burst from a nonzero base must wrap the index. The two busy cycles exercise both the counting and the exit branch of the wait state. A mismatched coprocessor number, or a wrong class field, reaches the reject path.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    // Instruction field positions (layout owned by this block)
    localparam int CLS_LSB   = 25;
    localparam int LOAD_BIT  = 20;
    localparam int BASE_LSB  = 12;
    localparam int CPN_LSB   = 8;
    localparam int CNT_LSB   = 0;
    localparam int FIELD_W   = 4;
    localparam logic [2:0] CLS_XFER = 3'b110;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REJECT = 2'd1,
        ST_WAIT   = 2'd2,
        ST_XFER   = 2'd3
    } cpx_state_e;

    typedef struct packed {
        logic               is_xfer;
        logic               is_load;
        logic [FIELD_W-1:0] cpnum;
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] cnt_m1;
    } cpx_ins_t;

    function automatic cpx_ins_t cpx_decode(input logic [31:0] w);
        cpx_ins_t d;
        d.is_xfer = (w[CLS_LSB +: 3] == CLS_XFER);
        d.is_load = w[LOAD_BIT];
        d.cpnum   = w[CPN_LSB  +: FIELD_W];
        d.base    = w[BASE_LSB +: FIELD_W];
        d.cnt_m1  = w[CNT_LSB  +: FIELD_W];
        return d;
    endfunction

endpackage

// File: rtl/cpx_snoop.sv
module cpx_snoop #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] instr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_q <= '0;
        end else if (cap_en) begin
            instr_q <= bus_in;
        end
    end

endmodule

// File: rtl/cpx_regfile.sv
module cpx_regfile #(
    parameter int DW    = 32,
    parameter int NREGS = 16,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/cpx_fsm.sv
module cpx_fsm
    import cpx_pkg::*;
#(
    parameter logic [FIELD_W-1:0] CP_ID    = 4'd5,
    parameter int                 BUSY_CYC = 2,
    parameter int                 AW       = 4,
    localparam int                BCW      = $clog2(BUSY_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_i,
    input  cpx_ins_t      ins,
    output cpx_state_e    state_q,
    output logic          absent_o,
    output logic          busy_o,
    output logic          xfer_o,
    output logic          load_o,
    output logic [AW-1:0] ptr_o
);

    cpx_state_e         state_d;
    logic [BCW-1:0]     bcnt_q, bcnt_d;
    logic [FIELD_W-1:0] rem_q, rem_d;
    logic [AW-1:0]      ptr_q, ptr_d;
    logic               load_q, load_d;
    logic               hit;

    assign hit = ins.is_xfer && (ins.cpnum == CP_ID);

    // next-state and datapath counters
    always_comb begin
        state_d = state_q;
        bcnt_d  = bcnt_q;
        rem_d   = rem_q;
        ptr_d   = ptr_q;
        load_d  = load_q;
        unique case (state_q)
            ST_IDLE: begin
                if (issue_i) begin
                    if (hit) begin
                        state_d = ST_WAIT;
                        bcnt_d  = BCW'(BUSY_CYC - 1);
                        rem_d   = ins.cnt_m1;
                        ptr_d   = ins.base[AW-1:0];
                        load_d  = ins.is_load;
                    end else begin
                        state_d = ST_REJECT;
                    end
                end
            end
            ST_REJECT: begin
                state_d = ST_IDLE;
            end
            ST_WAIT: begin
                if (bcnt_q == '0) begin
                    state_d = ST_XFER;
                end else begin
                    bcnt_d = bcnt_q - 1'b1;
                end
            end
            ST_XFER: begin
                if (rem_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    rem_d = rem_q - 1'b1;
                    ptr_d = ptr_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bcnt_q  <= '0;
            rem_q   <= '0;
            ptr_q   <= '0;
            load_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            bcnt_q  <= bcnt_d;
            rem_q   <= rem_d;
            ptr_q   <= ptr_d;
            load_q  <= load_d;
        end
    end

    // outputs
    always_comb begin
        absent_o = 1'b0;
        busy_o   = 1'b0;
        xfer_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_REJECT: absent_o = 1'b1;
            ST_WAIT:   busy_o   = 1'b1;
            ST_XFER: begin
                xfer_o   = 1'b1;
                absent_o = (rem_q == '0);
                busy_o   = (rem_q == '0);
            end
            default: ;
        endcase
    end

    assign load_o = load_q;
    assign ptr_o  = ptr_q;

    AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && issue_i && !hit) |=> (absent_o && !busy_o)); // R3
    AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && issue_i && hit) |=> (busy_o && !absent_o)); // R4
    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && rem_q != '0) |=> (state_q == ST_XFER && ptr_q == $past(ptr_q) + 1'b1)); // R5
    AST_TERM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (absent_o && busy_o) |=> (state_q == ST_IDLE && !absent_o && !busy_o)); // R6

endmodule

// File: rtl/cpx_xfer_seq.sv
module cpx_xfer_seq
    import cpx_pkg::*;
#(
    parameter int                 DW       = 32,
    parameter int                 NREGS    = 16,
    parameter logic [FIELD_W-1:0] CP_ID    = 4'd5,
    parameter int                 BUSY_CYC = 2,
    localparam int                AW       = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_i,
    input  logic          issue_i,
    input  logic          bus_en_i,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic          absent_o,
    output logic          busy_o
);

    cpx_state_e    state;
    logic [DW-1:0] instr_q;
    cpx_ins_t      ins;
    logic          xfer, load, rf_we;
    logic [AW-1:0] ptr;

    cpx_snoop #(.DW(DW)) u_snoop (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (fetch_i && state == ST_IDLE),
        .bus_in  (bus_in),
        .instr_q (instr_q)
    );

    assign ins = cpx_decode(instr_q[31:0]);

    cpx_fsm #(.CP_ID(CP_ID), .BUSY_CYC(BUSY_CYC), .AW(AW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (issue_i),
        .ins      (ins),
        .state_q  (state),
        .absent_o (absent_o),
        .busy_o   (busy_o),
        .xfer_o   (xfer),
        .load_o   (load),
        .ptr_o    (ptr)
    );

    assign rf_we = xfer && load;

    cpx_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (ptr),
        .wdata (bus_in),
        .raddr (ptr),
        .rdata (bus_out)
    );

    assign bus_oe = bus_en_i && xfer && !load;

    AST_SNOOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT || state == ST_XFER) |=> $stable(instr_q)); // R2
    AST_NO_DRIVE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!rf_we && busy_o == absent_o)); // R8

endmodule

// File: tb/sim_cpx_xfer_seq.sv
module sim_cpx_xfer_seq;

    localparam int CLK_P = 10;
    localparam int BUSY  = 2;
    localparam int CPID  = 5;

    logic        clk = 1'b0;
    logic        rst_n, fetch_i, issue_i, bus_en_i;
    logic [31:0] bus_in, bus_out;
    logic        bus_oe, absent_o, busy_o;

    int          n_vec = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    logic [31:0] mdl [16];
    logic [31:0] cur_ins;

    always #(CLK_P/2) clk = ~clk;

    cpx_xfer_seq u0 (
        .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .issue_i(issue_i),
        .bus_en_i(bus_en_i), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .absent_o(absent_o), .busy_o(busy_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input logic [2:0] cls, input bit ld,
                                       input logic [3:0] base, input logic [3:0] cp,
                                       input logic [3:0] cm1);
        logic [31:0] w;
        w = $urandom;
        w[27:25] = cls;
        w[20]    = ld;
        w[15:12] = base;
        w[11:8]  = cp;
        w[3:0]   = cm1;
        return w;
    endfunction

    function automatic bit is_hit(input logic [31:0] w);
        return (w[27:25] == 3'b110) && (w[11:8] == 4'(CPID));
    endfunction

    task automatic reset_model();
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        cur_ins = '0;
    endtask

    task automatic do_fetch(input logic [31:0] w);
        @(negedge clk);
        issue_i = 1'b0; fetch_i = 1'b1; bus_in = w;
        cur_ins = w;
    endtask

    task automatic run_issue(input bit junk_fetch);
        int n;
        bit ld;
        logic [3:0] base;
        @(negedge clk);
        fetch_i = 1'b0; issue_i = 1'b1; bus_en_i = 1'b1;
        #1;
        chk("R1 idle absent", 32'(absent_o), 0);
        chk("R1 idle busy", 32'(busy_o), 0);
        if (!is_hit(cur_ins)) begin
            @(negedge clk);
            issue_i = 1'b0;
            #1;
            chk("R3 reject absent", 32'(absent_o), 1);
            chk("R3 reject busy", 32'(busy_o), 0);
            chk("R3 reject oe", 32'(bus_oe), 0);
            @(negedge clk);
            #1;
            chk("R3 back idle absent", 32'(absent_o), 0);
            return;
        end
        n    = int'(cur_ins[3:0]) + 1;
        ld   = cur_ins[20];
        base = cur_ins[15:12];
        for (int b = 0; b < BUSY; b++) begin
            @(negedge clk);
            issue_i = 1'b0; bus_en_i = 1'($urandom);
            #1;
            chk("R4 busy high", 32'(busy_o), 1);
            chk("R4 absent low", 32'(absent_o), 0);
            chk("R8 oe low in wait", 32'(bus_oe), 0);
        end
        for (int k = 0; k < n; k++) begin
            logic [3:0] idx;
            idx = base + 4'(k);
            @(negedge clk);
            bus_en_i = 1'($urandom);
            fetch_i  = junk_fetch ? 1'($urandom) : 1'b0;
            bus_in   = $urandom;
            #1;
            chk("R6 busy at word", 32'(busy_o), 32'(k == n - 1));
            chk("R6 absent at word", 32'(absent_o), 32'(k == n - 1));
            chk("R8 oe gate", 32'(bus_oe), 32'(!ld && bus_en_i));
            if (!ld) chk("R8 R10 store data", bus_out, mdl[idx]);
            else     mdl[idx] = bus_in;
        end
        @(negedge clk);
        fetch_i = 1'b0;
        #1;
        chk("R6 idle after end busy", 32'(busy_o), 0);
        chk("R6 idle after end absent", 32'(absent_o), 0);
        chk("R6 idle after end oe", 32'(bus_oe), 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; fetch_i = 1'b0; issue_i = 1'b0; bus_en_i = 1'b0; bus_in = '0;
        reset_model();
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset absent", 32'(absent_o), 0);
        chk("R1 reset busy", 32'(busy_o), 0);
        chk("R1 reset oe", 32'(bus_oe), 0);
        rst_n = 1'b1;

        // R1: registers read zero after reset (store before any load)
        do_fetch(mk(3'b110, 1'b0, 4'd3, 4'(CPID), 4'd1)); run_issue(1'b0);
        // R7 R10: full 16-word load, then full store from a wrapping base
        do_fetch(mk(3'b110, 1'b1, 4'd0, 4'(CPID), 4'd15)); run_issue(1'b0);
        do_fetch(mk(3'b110, 1'b0, 4'd9, 4'(CPID), 4'd15)); run_issue(1'b0);
        // R10: short load across the wrap point
        do_fetch(mk(3'b110, 1'b1, 4'd14, 4'(CPID), 4'd3)); run_issue(1'b0);
        // R5: single word store
        do_fetch(mk(3'b110, 1'b0, 4'd15, 4'(CPID), 4'd0)); run_issue(1'b0);
        // R3: wrong coprocessor number, then wrong class
        do_fetch(mk(3'b110, 1'b0, 4'd0, 4'(CPID + 1), 4'd2)); run_issue(1'b0);
        do_fetch(mk(3'b010, 1'b1, 4'd0, 4'(CPID), 4'd2)); run_issue(1'b0);
        // R2: junk fetches during a burst, then reissue without a fetch
        do_fetch(mk(3'b110, 1'b0, 4'd2, 4'(CPID), 4'd5)); run_issue(1'b1);
        run_issue(1'b0);

        // random mix
        for (int t = 0; t < 80; t++) begin
            logic [3:0] cp;
            cp = ($urandom % 8 == 0) ? 4'($urandom) : 4'(CPID);
            do_fetch(mk(($urandom % 10 == 0) ? 3'($urandom) : 3'b110,
                        1'($urandom), 4'($urandom), cp, 4'($urandom)));
            run_issue(1'($urandom));
        end

        // R9: reset in the middle of a store burst
        do_fetch(mk(3'b110, 1'b0, 4'd0, 4'(CPID), 4'd7));
        @(negedge clk);
        fetch_i = 1'b0; issue_i = 1'b1; bus_en_i = 1'b1;
        @(negedge clk);
        issue_i = 1'b0;
        repeat (BUSY + 1) @(negedge clk);
        #1;
        chk("R9 oe before reset", 32'(bus_oe), 1);
        #1 rst_n = 1'b0;
        #1;
        chk("R9 oe dropped", 32'(bus_oe), 0);
        chk("R9 busy dropped", 32'(busy_o), 0);
        chk("R9 absent dropped", 32'(absent_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        reset_model();
        // R1: registers cleared again
        do_fetch(mk(3'b110, 1'b0, 4'd0, 4'(CPID), 4'd2)); run_issue(1'b0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule